// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and a 16-bit asynchronous static RAM. The RAM has a 17-bit word address and two active-low chip enables, one per byte lane, plus active-low write and output enables. The host presents a request through a valid/ready handshake. A request carries a word address, 16 bits of write data, a 2-bit lane mask and a read/write flag. Reads return their data with a one-cycle valid strobe.

Every pin interval comes from a down-counter. Its load value is a nanosecond parameter divided by the clock period and rounded up. The controller holds the address steady while any chip enable is low. It keeps the output enable high whenever it writes, and it separates its own bus drive from the device's drive by at least one cycle. The data bus is split into an output, an output enable and an input, so a pad ring can form the tri-state pins.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, all chip enables, write enable and output enable are high. The bus drive enable is 0, `reqReady` is 1 and `rspValid` is 0.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` then stays 0 until the whole sequence, including its recovery or float gap, is over.
- R3: A write with a non-zero mask starts with one setup cycle. In it the address and write data are driven, and all enables stay high. Next comes the write pulse: the write enable is low together with the selected chip enables, for ceil(max(tWP, tDS)/tCLK) cycles. At defaults this is 11 cycles. Mask bit 1 selects the upper chip enable (data bits 15:8) and mask bit 0 selects the lower chip enable (bits 7:0).
- R4: The write ends with the write enable and the chip enables rising on the same edge. The write data stays driven for one more cycle. The write enable then stays high for max(ceil(tWR/tCLK), ceil(tWC/tCLK) - 1 - pulse) cycles in total, which is 3 at defaults.
- R5: A read with a non-zero mask holds the selected chip enables and the output enable low, with the write enable high. This lasts ceil(max(tRC, tACC, tCO, tOE)/tCLK) cycles, which is 14 at defaults. The data bus is sampled at the end of the last of these cycles.
- R6: `rspValid` is 1 for exactly one cycle, the one right after the last read access cycle. `rspData` holds the sampled lanes that the mask selects; a lane the mask does not select reads as 0.
- R7: After a read, all enables stay high for ceil(tOD/tCLK) cycles, 5 at defaults, before `reqReady` returns to 1.
- R8: The output enable is never low while the write enable is low or the bus drive enable is 1.
- R9: The bus drive enable is 1 only in a cycle where the output enable is high and was also high in the cycle before. The output enable goes low only in a cycle that follows one with the bus drive enable at 0.
- R10: A request with mask 00 asserts no chip enable and keeps `reqReady` at 0 for one cycle. For a read, `rspValid` is 1 in the following cycle with `rspData` equal to 0. A write with mask 00 leaves the memory unchanged.
- R11: The address output does not change between two consecutive cycles in which some chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| rspValid | output | 1 | Read data valid strobe |
| rspData | output | 16 | Read data, unselected lanes zero |
| memAddr | output | 17 | RAM address |
| memCeUN | output | 1 | Upper-byte chip enable, active low |
| memCeLN | output | 1 | Lower-byte chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 16 | Data toward the RAM |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data from the RAM |

## Verification
The assertions take the memory-side input as only loosely constrained. `memDqIn` may be undefined or floating, except on the lanes the mask selects during the read window, and no property depends on its value. The bench's behavioural RAM returns data only while the output enable and its lane's chip enable are low and the write enable is high, and it floats otherwise. The bench also treats a request as held only until the edge that accepts it. To keep to that, it raises `reqValid` only in cycles where the reference model expects `reqReady` to be 1, and drops it one step after the accepting edge.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // take a new request into the holding registers
    logic capture;  // sample the bus into the read register
    logic respond;  // raise the read valid strobe next cycle
    logic ceAct;    // chip enables active for the masked lanes
    logic weAct;    // write enable active
    logic oeAct;    // output enable active
    logic drive;    // controller drives the data bus
  } ctlStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int MASK_W   = 2,
  parameter int CLK_NS   = 5,
  parameter int T_WP_NS  = 55,
  parameter int T_DS_NS  = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_WR_NS  = 15,
  parameter int T_RC_NS  = 70,
  parameter int T_ACC_NS = 70,
  parameter int T_CO_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_OD_NS  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [MASK_W-1:0] reqMask,
  output logic              reqReady,
  output ctlStrobes_t       ctl
);

  localparam int WP_CYC  = ceilDiv(maxOf(T_WP_NS, T_DS_NS), CLK_NS);
  localparam int REC_CYC = maxOf(ceilDiv(T_WR_NS, CLK_NS),
                                 ceilDiv(T_WC_NS, CLK_NS) - 1 - WP_CYC);
  localparam int ACC_CYC = ceilDiv(maxOf(maxOf(T_RC_NS, T_ACC_NS),
                                         maxOf(T_CO_NS, T_OE_NS)), CLK_NS);
  localparam int HIZ_CYC = maxOf(ceilDiv(T_OD_NS, CLK_NS), 1);
  localparam int CNT_MAX = maxOf(maxOf(WP_CYC, REC_CYC), maxOf(ACC_CYC, HIZ_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WREC, S_RACC, S_RHIZ, S_ZERO
  } seqState_t;

  seqState_t         stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic              zeroReadQ;
  logic              cntDone;

  assign cntDone  = (cntQ == '0);
  assign reqReady = (stateQ == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      cntQ      <= '0;
      zeroReadQ <= 1'b0;
    end else begin
      unique case (stateQ)
        S_IDLE: if (reqValid) begin
          if (reqMask == '0) begin
            stateQ    <= S_ZERO;
            zeroReadQ <= !reqWrite;
          end else if (reqWrite) begin
            stateQ <= S_WSET;
          end else begin
            stateQ <= S_RACC;
            cntQ   <= CNT_W'(ACC_CYC - 1);
          end
        end
        S_WSET: begin
          stateQ <= S_WPUL;
          cntQ   <= CNT_W'(WP_CYC - 1);
        end
        S_WPUL: if (cntDone) begin
          stateQ <= S_WREC;
          cntQ   <= CNT_W'(REC_CYC - 1);
        end else cntQ <= cntQ - 1'b1;
        S_WREC: if (cntDone) stateQ <= S_IDLE;
                else cntQ <= cntQ - 1'b1;
        S_RACC: if (cntDone) begin
          stateQ <= S_RHIZ;
          cntQ   <= CNT_W'(HIZ_CYC - 1);
        end else cntQ <= cntQ - 1'b1;
        S_RHIZ: if (cntDone) stateQ <= S_IDLE;
                else cntQ <= cntQ - 1'b1;
        S_ZERO: stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (stateQ == S_IDLE) && reqValid;
    ctl.capture = ((stateQ == S_RACC) && cntDone) || ((stateQ == S_ZERO) && zeroReadQ);
    ctl.respond = ctl.capture;
    ctl.ceAct   = (stateQ == S_WPUL) || (stateQ == S_RACC);
    ctl.weAct   = (stateQ == S_WPUL);
    ctl.oeAct   = (stateQ == S_RACC);
    ctl.drive   = (stateQ == S_WSET) || (stateQ == S_WPUL) ||
                  ((stateQ == S_WREC) && (cntQ == CNT_W'(REC_CYC - 1)));
  end

  // R10
  zero_mask_no_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMask == '0) |=> !ctl.ceAct);

  // R4
  write_end_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.weAct) && !ctl.weAct) |-> (!ctl.ceAct && ctl.drive));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANE_W = 8,
  parameter int MASK_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                ctl,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [MASK_W*LANE_W-1:0]   reqWdata,
  input  logic [MASK_W-1:0]          reqMask,
  input  logic [MASK_W*LANE_W-1:0]   memDqIn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memCeUN,
  output logic                       memCeLN,
  output logic                       memWeN,
  output logic                       memOeN,
  output logic [MASK_W*LANE_W-1:0]   memDqOut,
  output logic                       memDqOe,
  output logic                       rspValid,
  output logic [MASK_W*LANE_W-1:0]   rspData
);

  localparam int DATA_W = MASK_W * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ, laneBits;
  logic [MASK_W-1:0] maskQ;
  logic              rspValidQ;

  for (genvar g = 0; g < MASK_W; g++) begin : g_lane
    assign laneBits[g*LANE_W +: LANE_W] = {LANE_W{maskQ[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      maskQ     <= '0;
      rdataQ    <= '0;
      rspValidQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        maskQ  <= reqMask;
      end
      if (ctl.capture) rdataQ <= memDqIn & laneBits;
      rspValidQ <= ctl.respond;
    end
  end

  assign memAddr  = addrQ;
  assign memCeUN  = !(ctl.ceAct && maskQ[MASK_W-1]);
  assign memCeLN  = !(ctl.ceAct && maskQ[0]);
  assign memWeN   = !ctl.weAct;
  assign memOeN   = !ctl.oeAct;
  assign memDqOut = wdataQ;
  assign memDqOe  = ctl.drive;
  assign rspValid = rspValidQ;
  assign rspData  = rdataQ;

  // R8
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || memDqOe) |-> memOeN);

  // R9
  drive_after_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && $past(memOeN)));

  // R9
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !$past(memDqOe));

  // R11
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!memCeUN || !memCeLN) && $past(!memCeUN || !memCeLN)) |-> $stable(memAddr));

  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_WP_NS  = 55,
  parameter int T_DS_NS  = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_WR_NS  = 15,
  parameter int T_RC_NS  = 70,
  parameter int T_ACC_NS = 70,
  parameter int T_CO_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_OD_NS  = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic [1:0]          reqMask,
  output logic                rspValid,
  output logic [2*LANE_W-1:0] rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeUN,
  output logic                memCeLN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [2*LANE_W-1:0] memDqOut,
  output logic                memDqOe,
  input  logic [2*LANE_W-1:0] memDqIn
);

  localparam int MASK_W = 2;

  ctlStrobes_t ctl;

  sram_lane_seq #(
    .MASK_W(MASK_W), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS),
    .T_WC_NS(T_WC_NS), .T_WR_NS(T_WR_NS), .T_RC_NS(T_RC_NS),
    .T_ACC_NS(T_ACC_NS), .T_CO_NS(T_CO_NS), .T_OE_NS(T_OE_NS), .T_OD_NS(T_OD_NS)
  ) i_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .ctl(ctl)
  );

  sram_lane_dp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .MASK_W(MASK_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .memDqIn(memDqIn), .memAddr(memAddr), .memCeUN(memCeUN),
    .memCeLN(memCeLN), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/100ps
module test_sram_lane_ctrl;

  // cycle counts from the requirements at 5 ns: ceil(55/5), ceil(70/5),
  // max(ceil(15/5), 14-1-11), ceil(25/5)
  localparam int WP  = 11;
  localparam int ACC = 14;
  localparam int REC = 3;
  localparam int HIZ = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rspValid, memCeUN, memCeLN, memWeN, memOeN, memDqOe;
  logic [15:0] rspData, memDqOut, memDqIn;
  logic [16:0] memAddr;

  always #2.5 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCeUN(memCeUN),
    .memCeLN(memCeLN), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural RAM
  logic [15:0] devMem [int];
  logic        weLowSeen = 1'b0;
  logic        latU = 1'b0, latL = 1'b0;

  always @(negedge clk) begin
    if (!memWeN) begin
      weLowSeen <= 1'b1;
      latU <= !memCeUN;
      latL <= !memCeLN;
    end else if (weLowSeen) begin
      logic [15:0] cur;
      cur = devMem.exists(int'(memAddr)) ? devMem[int'(memAddr)] : 16'h0;
      if (latU) cur[15:8] = memDqOut[15:8];
      if (latL) cur[7:0]  = memDqOut[7:0];
      devMem[int'(memAddr)] = cur;
      weLowSeen <= 1'b0;
    end
  end

  always begin
    logic [15:0] word;
    @(posedge clk);
    #1;
    word = devMem.exists(int'(memAddr)) ? devMem[int'(memAddr)] : 16'h0;
    memDqIn[15:8] = (!memOeN && memWeN && !memCeUN) ? word[15:8] : 8'hzz;
    memDqIn[7:0]  = (!memOeN && memWeN && !memCeLN) ? word[7:0]  : 8'hzz;
  end

  // reference model: queue of per-cycle expected pin states
  typedef struct {
    bit ready; bit ceU; bit ceL; bit we; bit oe; bit dqOe;
    logic [16:0] addr; logic [15:0] dq; bit rv; logic [15:0] rd; int req;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] shadow [int];
  int          errors = 0, checks = 0, cycles = 0;
  bit          running = 1'b0, finished = 1'b0;

  function automatic exp_t idleExp();
    exp_t e;
    e.ready = 1; e.ceU = 1; e.ceL = 1; e.we = 1; e.oe = 1; e.dqOe = 0;
    e.addr = '0; e.dq = '0; e.rv = 0; e.rd = '0; e.req = 2;
    return e;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      bit bad;
      e = (expQ.size() > 0) ? expQ.pop_front() : idleExp();
      bad = (reqReady !== e.ready) || (memCeUN !== e.ceU) || (memCeLN !== e.ceL) ||
            (memWeN !== e.we) || (memOeN !== e.oe) || (memDqOe !== e.dqOe) ||
            (rspValid !== e.rv);
      if ((!e.ceU || !e.ceL || e.dqOe) && memAddr !== e.addr) bad = 1;
      if (e.dqOe && memDqOut !== e.dq) bad = 1;
      if (e.rv && rspData !== e.rd) bad = 1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL R%0d cycle %0d: act rdy=%b ceU=%b ceL=%b we=%b oe=%b drv=%b a=%h dq=%h rv=%b rd=%h exp rdy=%b ceU=%b ceL=%b we=%b oe=%b drv=%b a=%h dq=%h rv=%b rd=%h",
          e.req, cycles, reqReady, memCeUN, memCeLN, memWeN, memOeN, memDqOe, memAddr,
          memDqOut, rspValid, rspData, e.ready, e.ceU, e.ceL, e.we, e.oe, e.dqOe,
          e.addr, e.dq, e.rv, e.rd);
      end
    end
  end

  function automatic exp_t busy(input int rq, input logic [16:0] a);
    exp_t e;
    e = idleExp();
    e.ready = 0; e.addr = a; e.req = rq;
    return e;
  endfunction

  task automatic doReq(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    int n;
    exp_t e;
    logic [15:0] old, rdExp;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    #1;
    reqValid = 0; reqAddr = ~a; reqWdata = ~d;
    n = 0;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    if (m == 2'b00) begin
      // R10: one busy cycle, no chip enable; read answers 0 next cycle
      e = busy(10, a); expQ.push_back(e); n++;
      if (!wr) begin
        e = idleExp(); e.rv = 1; e.rd = 16'h0; e.req = 10;
        expQ.push_back(e); n++;
      end
    end else if (wr) begin
      // R3: setup cycle then pulse with selected lanes
      e = busy(3, a); e.dqOe = 1; e.dq = d; expQ.push_back(e); n++;
      for (int i = 0; i < WP; i++) begin
        e = busy(3, a); e.dqOe = 1; e.dq = d; e.we = 0;
        e.ceU = !m[1]; e.ceL = !m[0]; expQ.push_back(e); n++;
      end
      // R4: data hold, then recovery with write enable high
      for (int i = 0; i < REC; i++) begin
        e = busy(4, a); e.dqOe = (i == 0); e.dq = d; expQ.push_back(e); n++;
      end
      if (m[1]) old[15:8] = d[15:8];
      if (m[0]) old[7:0]  = d[7:0];
      shadow[int'(a)] = old;
    end else begin
      // R5: access window
      for (int i = 0; i < ACC; i++) begin
        e = busy(5, a); e.oe = 0; e.ceU = !m[1]; e.ceL = !m[0];
        expQ.push_back(e); n++;
      end
      // R6: response with masked lanes; R7: float gap
      rdExp = {m[1] ? old[15:8] : 8'h00, m[0] ? old[7:0] : 8'h00};
      for (int i = 0; i < HIZ; i++) begin
        e = busy(i == 0 ? 6 : 7, a);
        if (i == 0) begin e.rv = 1; e.rd = rdExp; end
        expQ.push_back(e); n++;
      end
    end
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (!(memCeUN && memCeLN && memWeN && memOeN && !memDqOe && reqReady && !rspValid)) begin
      errors++;
      $display("FAIL R1: act ce=%b%b we=%b oe=%b drv=%b rdy=%b rv=%b exp 1 1 1 1 0 1 0",
               memCeUN, memCeLN, memWeN, memOeN, memDqOe, reqReady, rspValid);
    end
    @(posedge clk); #1;
    rstN = 1;
    running = 1;
    @(posedge clk); #1;
    doReq(1, 17'h00010, 16'hA55A, 2'b11);  // R3 full word
    doReq(0, 17'h00010, 16'h0,    2'b11);  // R5 R6 full read
    doReq(1, 17'h1FFFF, 16'h1234, 2'b10);  // R3 upper only
    doReq(1, 17'h1FFFF, 16'hEEEE, 2'b01);  // lower only
    doReq(0, 17'h1FFFF, 16'h0,    2'b11);
    doReq(0, 17'h1FFFF, 16'h0,    2'b10);  // R6 unselected lower reads 0
    doReq(0, 17'h1FFFF, 16'h0,    2'b01);  // R6 unselected upper reads 0
    doReq(1, 17'h00010, 16'hFFFF, 2'b00);  // R10 zero-mask write
    doReq(0, 17'h00010, 16'h0,    2'b11);  // R10 memory unchanged
    doReq(0, 17'h00000, 16'h0,    2'b00);  // R10 zero-mask read
    doReq(0, 17'h00000, 16'h0,    2'b11);  // unwritten
    for (int k = 0; k < 60; k++) begin
      logic [16:0] a;
      a = 17'($urandom_range(0, 7)) | (17'($urandom_range(0, 3)) << 15);
      doReq(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
      repeat ($urandom_range(0, 2)) @(posedge clk);
      #0;
    end
    repeat (4) @(posedge clk);
    #1;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act cycles=%0d exp finish earlier", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule